// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block makes the keep-or-discard decision for each received Ethernet frame from its parsed destination and source addresses. A parser upstream presents both 48-bit addresses, together with flags marking control and pause frames, and pulses a strobe. One clock later the filter returns a forward bit and two status flags, one for a destination failure and one for a source failure, which the receive path copies into the frame's status word.

Matching uses a fixed station address plus a parameterised bank of extra address slots. The station address is always active, always checks the destination and compares all six bytes. Each extra slot has its own enable, a six-bit byte mask that excludes chosen bytes from the compare so that a slot can match a group of addresses, and a select that points it at the source address instead of the destination.

Mode inputs control the outcome: inverse matching for either address, dropping on a source failure, passing all multicast, blocking broadcast, promiscuous operation, receive-all, and a two-bit policy for control frames.

Top module: `rxaf_top`

## Requirements
- R1: While reset is held and on the first cycle after it, `res_vld`, `fwd`, `da_fail` and `sa_fail` are all 0.
- R2: `res_vld` is 1 in exactly the cycle after each cycle in which `addr_vld` is sampled high, and 0 otherwise. The verdict outputs change only on those cycles and keep their values in between.
- R3: A destination matches when it equals `station_addr`, or when it equals the address of an enabled slot whose `slot_use_sa` is 0, in every byte whose mask bit is 0. Address byte i is bits [8i+7:8i], and mask bit i covers byte i.
- R4: A slot with `slot_use_sa` = 1 is compared only with the source address. A slot with `slot_en` = 0 never matches either address.
- R5: With `da_invert` = 1, the destination match result is inverted for every frame decided by address match, whether unicast or multicast.
- R6: A source match means an enabled source slot matches under its mask. With `sa_invert` = 0 a frame fails the source check when no source slot matches. With `sa_invert` = 1 it fails when one does. `sa_fail` reports this result.
- R7: With `sa_filter_en` = 1, a frame that fails the source check is not forwarded. With it 0, the source result only sets `sa_fail`.
- R8: A destination whose bit 0 is 1 (multicast) passes the destination check when `pass_all_mcast` = 1.
- R9: An all-ones destination (broadcast) passes the destination check unless `block_bcast` = 1. In that case the frame is never forwarded in any mode, and `da_fail` = 1 unless promiscuous.
- R10: With `promisc` = 1, `da_fail` and `sa_fail` are 0 and every non-control frame is forwarded, apart from the R9 override.
- R11: With `rx_all` = 1, every non-control frame is forwarded apart from the R9 override, and `da_fail` and `sa_fail` still report the filter results.
- R12: For a frame with `is_ctrl` = 1, `fwd` follows only `ctrl_policy`: 00 never forwards; 01 forwards unless `is_pause` = 1; 10 always forwards; 11 forwards only when the frame passes the filter (promiscuous, or a destination pass without an R7 source drop). The R9 override still applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_vld | input | 1 | Strobe: the addresses and flags are valid this cycle |
| rx_da | input | 48 | Destination address of the frame |
| rx_sa | input | 48 | Source address of the frame |
| is_ctrl | input | 1 | The frame is a control frame |
| is_pause | input | 1 | The control frame is a pause frame |
| station_addr | input | 48 | Primary station address |
| slot_addr | input | NSLOT×48 | Address of each extra slot |
| slot_mask | input | NSLOT×6 | Per-byte compare mask of each slot (1 = ignore byte) |
| slot_en | input | NSLOT | Slot enable |
| slot_use_sa | input | NSLOT | Slot compares the source address when 1 |
| promisc | input | 1 | Promiscuous mode |
| da_invert | input | 1 | Inverse destination matching |
| sa_invert | input | 1 | Inverse source matching |
| sa_filter_en | input | 1 | A source failure drops the frame |
| pass_all_mcast | input | 1 | Pass every multicast destination |
| block_bcast | input | 1 | Drop every broadcast frame |
| rx_all | input | 1 | Forward regardless of the filter result |
| ctrl_policy | input | 2 | Forwarding policy for control frames |
| res_vld | output | 1 | Verdict valid pulse |
| fwd | output | 1 | Forward the frame |
| da_fail | output | 1 | Destination filter failed |
| sa_fail | output | 1 | Source filter failed |

## Verification
The assertions assume that every configuration input and both addresses are stable in the cycle `addr_vld` is high, and that `is_pause` is only meaningful together with `is_ctrl`. The stimulus changes all inputs only on the falling clock edge, one frame per cycle, so these hold by construction. The bench fixes a slot layout that covers plain, masked, disabled and source-facing slots, then sweeps every combination of the eleven mode and frame-type bits against eight destination and three source patterns.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;

    typedef enum logic [0:0] {
        RX_IDLE = 1'b0,
        RX_EMIT = 1'b1
    } rxaf_state_t;

    typedef struct packed {
        logic fwd;
        logic da_fail;
        logic sa_fail;
    } rxaf_verdict_t;

    localparam logic [1:0] CTRL_NONE     = 2'b00;
    localparam logic [1:0] CTRL_NO_PAUSE = 2'b01;
    localparam logic [1:0] CTRL_ALL      = 2'b10;
    localparam logic [1:0] CTRL_FILTERED = 2'b11;

endpackage

// File: rtl/rxaf_slot_cmp.sv
module rxaf_slot_cmp #(
    parameter int ABYTES = 6
) (
    input  logic [ABYTES*8-1:0] slot_addr,
    input  logic [ABYTES-1:0]   slot_mask,
    input  logic                slot_en,
    input  logic                slot_use_sa,
    input  logic [ABYTES*8-1:0] da,
    input  logic [ABYTES*8-1:0] sa,
    output logic                da_hit,
    output logic                sa_hit
);
    logic [ABYTES*8-1:0] target;
    logic [ABYTES-1:0]   byte_ok;

    assign target = slot_use_sa ? sa : da;

    for (genvar b = 0; b < ABYTES; b++) begin : g_byte
        assign byte_ok[b] = slot_mask[b] ||
                            (target[8*b +: 8] == slot_addr[8*b +: 8]);
    end

    assign da_hit = slot_en && !slot_use_sa && (&byte_ok);
    assign sa_hit = slot_en &&  slot_use_sa && (&byte_ok);
endmodule

// File: rtl/rxaf_policy.sv
module rxaf_policy
    import rxaf_pkg::*;
(
    input  logic          da_hit,
    input  logic          sa_hit,
    input  logic          is_bcast,
    input  logic          is_mcast,
    input  logic          is_ctrl,
    input  logic          is_pause,
    input  logic          promisc,
    input  logic          da_invert,
    input  logic          sa_invert,
    input  logic          sa_filter_en,
    input  logic          pass_all_mcast,
    input  logic          block_bcast,
    input  logic          rx_all,
    input  logic [1:0]    ctrl_policy,
    output rxaf_verdict_t verdict
);
    logic da_ok;
    logic sa_bad;
    logic filt_pass;
    logic bcast_kill;
    logic ctrl_fwd;

    always_comb begin
        if (is_bcast)
            da_ok = !block_bcast;
        else if (is_mcast && pass_all_mcast)
            da_ok = 1'b1;
        else
            da_ok = da_hit ^ da_invert;
    end

    assign sa_bad     = sa_invert ? sa_hit : !sa_hit;
    assign filt_pass  = promisc || (da_ok && !(sa_filter_en && sa_bad));
    assign bcast_kill = is_bcast && block_bcast;

    always_comb begin
        unique case (ctrl_policy)
            CTRL_NONE:     ctrl_fwd = 1'b0;
            CTRL_NO_PAUSE: ctrl_fwd = !is_pause;
            CTRL_ALL:      ctrl_fwd = 1'b1;
            CTRL_FILTERED: ctrl_fwd = filt_pass;
            default:       ctrl_fwd = 1'b0;
        endcase
    end

    always_comb begin
        verdict.da_fail = !promisc && !da_ok;
        verdict.sa_fail = !promisc && sa_bad;
        if (bcast_kill)
            verdict.fwd = 1'b0;
        else if (is_ctrl)
            verdict.fwd = ctrl_fwd;
        else
            verdict.fwd = rx_all || filt_pass;
    end
endmodule

// File: rtl/rxaf_top.sv
module rxaf_top
    import rxaf_pkg::*;
#(
    parameter int NSLOT  = 7,
    parameter int ABYTES = 6
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           addr_vld,
    input  logic [ABYTES*8-1:0]            rx_da,
    input  logic [ABYTES*8-1:0]            rx_sa,
    input  logic                           is_ctrl,
    input  logic                           is_pause,
    input  logic [ABYTES*8-1:0]            station_addr,
    input  logic [NSLOT-1:0][ABYTES*8-1:0] slot_addr,
    input  logic [NSLOT-1:0][ABYTES-1:0]   slot_mask,
    input  logic [NSLOT-1:0]               slot_en,
    input  logic [NSLOT-1:0]               slot_use_sa,
    input  logic                           promisc,
    input  logic                           da_invert,
    input  logic                           sa_invert,
    input  logic                           sa_filter_en,
    input  logic                           pass_all_mcast,
    input  logic                           block_bcast,
    input  logic                           rx_all,
    input  logic [1:0]                     ctrl_policy,
    output logic                           res_vld,
    output logic                           fwd,
    output logic                           da_fail,
    output logic                           sa_fail
);
    localparam int AW = ABYTES * 8;

    logic [NSLOT-1:0] slot_da_hit;
    logic [NSLOT-1:0] slot_sa_hit;
    logic             da_hit;
    logic             sa_hit;
    logic             is_bcast;
    logic             is_mcast;
    rxaf_verdict_t    verdict_d;
    rxaf_verdict_t    verdict_q;
    rxaf_state_t      state_q;
    rxaf_state_t      state_d;

    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        rxaf_slot_cmp #(.ABYTES(ABYTES)) u_cmp (
            .slot_addr   (slot_addr[k]),
            .slot_mask   (slot_mask[k]),
            .slot_en     (slot_en[k]),
            .slot_use_sa (slot_use_sa[k]),
            .da          (rx_da),
            .sa          (rx_sa),
            .da_hit      (slot_da_hit[k]),
            .sa_hit      (slot_sa_hit[k])
        );
    end

    assign da_hit   = (rx_da == station_addr) || (|slot_da_hit);
    assign sa_hit   = |slot_sa_hit;
    assign is_bcast = (rx_da == {AW{1'b1}});
    assign is_mcast = rx_da[0];

    rxaf_policy u_policy (
        .da_hit         (da_hit),
        .sa_hit         (sa_hit),
        .is_bcast       (is_bcast),
        .is_mcast       (is_mcast),
        .is_ctrl        (is_ctrl),
        .is_pause       (is_pause),
        .promisc        (promisc),
        .da_invert      (da_invert),
        .sa_invert      (sa_invert),
        .sa_filter_en   (sa_filter_en),
        .pass_all_mcast (pass_all_mcast),
        .block_bcast    (block_bcast),
        .rx_all         (rx_all),
        .ctrl_policy    (ctrl_policy),
        .verdict        (verdict_d)
    );

    // Transitions: ACCEPT (IDLE->EMIT), CHAIN (EMIT->EMIT), RETIRE (EMIT->IDLE)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE: if (addr_vld) state_d = RX_EMIT;
            RX_EMIT: state_d = addr_vld ? RX_EMIT : RX_IDLE;
            default: state_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= RX_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            verdict_q <= '0;
        else if (addr_vld)
            verdict_q <= verdict_d;
    end

    assign res_vld = (state_q == RX_EMIT);
    assign fwd     = verdict_q.fwd;
    assign da_fail = verdict_q.da_fail;
    assign sa_fail = verdict_q.sa_fail;
endmodule

// File: rtl/rxaf_chk.sv
module rxaf_chk #(
    parameter int ABYTES = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic                addr_vld,
    input logic [ABYTES*8-1:0] rx_da,
    input logic                is_ctrl,
    input logic                promisc,
    input logic                block_bcast,
    input logic                rx_all,
    input logic [1:0]          ctrl_policy,
    input logic                res_vld,
    input logic                fwd,
    input logic                da_fail,
    input logic                sa_fail
);
    logic bc;
    assign bc = (rx_da == {(ABYTES*8){1'b1}});

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        addr_vld |=> res_vld);

    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_vld |=> !res_vld);

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_vld |=> ($stable(fwd) && $stable(da_fail) && $stable(sa_fail)));

    a_r9_block_bcast: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_vld && block_bcast && bc) |=> !fwd);

    a_r10_promisc_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_vld && promisc) |=> (!da_fail && !sa_fail));

    a_r11_rx_all: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_vld && rx_all && !is_ctrl && !(block_bcast && bc)) |=> fwd);

    a_r12_ctrl_none: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_vld && is_ctrl && ctrl_policy == 2'b00) |=> !fwd);
endmodule

bind rxaf_top rxaf_chk #(.ABYTES(ABYTES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_vld    (addr_vld),
    .rx_da       (rx_da),
    .is_ctrl     (is_ctrl),
    .promisc     (promisc),
    .block_bcast (block_bcast),
    .rx_all      (rx_all),
    .ctrl_policy (ctrl_policy),
    .res_vld     (res_vld),
    .fwd         (fwd),
    .da_fail     (da_fail),
    .sa_fail     (sa_fail)
);

// File: tb/tb_rxaf_top.sv
module tb_rxaf_top;
    localparam int NSLOT = 7;
    localparam int AB    = 6;
    localparam int AW    = AB * 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic addr_vld = 1'b0;
    logic [AW-1:0] rx_da = '0, rx_sa = '0, station_addr = '0;
    logic is_ctrl = 1'b0, is_pause = 1'b0;
    logic [NSLOT-1:0][AW-1:0] slot_addr = '0;
    logic [NSLOT-1:0][AB-1:0] slot_mask = '0;
    logic [NSLOT-1:0] slot_en = '0, slot_use_sa = '0;
    logic promisc = 0, da_invert = 0, sa_invert = 0, sa_filter_en = 0;
    logic pass_all_mcast = 0, block_bcast = 0, rx_all = 0;
    logic [1:0] ctrl_policy = 2'b00;
    logic res_vld, fwd, da_fail, sa_fail;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    rxaf_top #(.NSLOT(NSLOT), .ABYTES(AB)) dut (.*);

    localparam logic [AW-1:0] ST  = 48'h665544332210;
    localparam logic [AW-1:0] S0A = 48'h0F0E0D0C0B0A;
    localparam logic [AW-1:0] S1A = 48'h161514131220;
    localparam logic [AW-1:0] S2A = 48'h262524232240;
    localparam logic [AW-1:0] S3A = 48'h363534333260;
    localparam logic [AW-1:0] S4A = 48'h464544434280;

    task automatic chk(input logic act, input logic exp, input string tag, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] da_pat(input int i);
        case (i)
            0: return ST;
            1: return S0A;
            2: return S1A ^ (48'hFF << 40);
            3: return S1A ^ 48'h02;
            4: return S3A;
            5: return S2A;
            6: return 48'h777675747301;
            default: return {AW{1'b1}};
        endcase
    endfunction

    function automatic logic [AW-1:0] sa_pat(input int i);
        case (i)
            0: return S2A;
            1: return S4A ^ 48'h04;
            default: return 48'h5A5A5A5A5A5A;
        endcase
    endfunction

    function automatic logic slot_match(input int k, input logic [AW-1:0] a);
        for (int b = 0; b < AB; b++)
            if (!slot_mask[k][b] && a[8*b +: 8] != slot_addr[k][8*b +: 8]) return 1'b0;
        return 1'b1;
    endfunction

    initial begin
        #2_000_000;
        checks++; fails++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        station_addr = ST;
        slot_addr[0] = S0A; slot_en[0] = 1;
        slot_addr[1] = S1A; slot_en[1] = 1; slot_mask[1] = 6'b100000;
        slot_addr[2] = S2A; slot_en[2] = 1; slot_use_sa[2] = 1;
        slot_addr[3] = S3A; slot_en[3] = 0;
        slot_addr[4] = S4A; slot_en[4] = 1; slot_use_sa[4] = 1; slot_mask[4] = 6'b000001;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(res_vld, 0, "R1", "res_vld in reset");
        chk(fwd, 0, "R1", "fwd in reset");
        chk(da_fail, 0, "R1", "da_fail in reset");
        chk(sa_fail, 0, "R1", "sa_fail in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(res_vld, 0, "R1", "res_vld after reset");

        // Sweep: every mode / frame-type combination over all address patterns
        for (int m = 0; m < 2048; m++) begin
            for (int di = 0; di < 8; di++) begin
                for (int si = 0; si < 3; si++) begin
                    logic bc, mc, dh, sh, da_ok, sa_bad, filt, ef, ed, es, cf;
                    string ft, dt;
                    {promisc, da_invert, sa_invert, sa_filter_en, pass_all_mcast,
                     block_bcast, rx_all, ctrl_policy, is_ctrl, is_pause} = m[10:0];
                    rx_da = da_pat(di);
                    rx_sa = sa_pat(si);
                    addr_vld = 1'b1;
                    // expected
                    bc = (rx_da == {AW{1'b1}});
                    mc = rx_da[0];
                    dh = (rx_da == ST);
                    sh = 1'b0;
                    for (int k = 0; k < NSLOT; k++) begin
                        if (slot_en[k] && !slot_use_sa[k] && slot_match(k, rx_da)) dh = 1'b1;
                        if (slot_en[k] &&  slot_use_sa[k] && slot_match(k, rx_sa)) sh = 1'b1;
                    end
                    da_ok  = bc ? !block_bcast : ((mc && pass_all_mcast) ? 1'b1 : (dh ^ da_invert));
                    sa_bad = sa_invert ? sh : !sh;
                    filt   = promisc || (da_ok && !(sa_filter_en && sa_bad));
                    ed = !promisc && !da_ok;
                    es = !promisc && sa_bad;
                    case (ctrl_policy)
                        2'b00: cf = 1'b0;
                        2'b01: cf = !is_pause;
                        2'b10: cf = 1'b1;
                        default: cf = filt;
                    endcase
                    ef = (bc && block_bcast) ? 1'b0 : (is_ctrl ? cf : (rx_all || filt));
                    if (bc && block_bcast) ft = "R9";
                    else if (is_ctrl) ft = "R12";
                    else if (promisc) ft = "R10";
                    else if (rx_all) ft = "R11";
                    else if (sa_filter_en && sa_bad) ft = "R7";
                    else ft = "R3";
                    if (bc) dt = "R9";
                    else if (mc && pass_all_mcast) dt = "R8";
                    else if (da_invert) dt = "R5";
                    else if (di == 4 || di == 5) dt = "R4";
                    else dt = "R3";
                    @(negedge clk);
                    chk(res_vld, 1'b1, "R2", "res_vld after strobe");
                    chk(fwd, ef, ft, "fwd");
                    chk(da_fail, ed, dt, "da_fail");
                    chk(sa_fail, es, "R6", "sa_fail");
                end
            end
        end

        // R2: idle cycle holds verdict and drops valid
        begin
            logic f0, d0, s0;
            f0 = fwd; d0 = da_fail; s0 = sa_fail;
            addr_vld = 1'b0;
            rx_da = ST; rx_sa = S2A; promisc = 1'b1; ctrl_policy = 2'b10;
            @(negedge clk);
            chk(res_vld, 1'b0, "R2", "res_vld idle");
            chk(fwd, f0, "R2", "fwd held");
            chk(da_fail, d0, "R2", "da_fail held");
            chk(sa_fail, s0, "R2", "sa_fail held");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule